// File: doc/BRIEF.md
# MSI Doorbell Interrupt Frame

This block sits on a simple 32-bit register bus and turns message-signalled interrupt writes into interrupt-line pulses. A device writes an absolute interrupt number to the doorbell register. The frame subtracts the first number it serves from that value. If the difference falls inside its range of lines, the frame raises that line for one clock. Numbers outside the range are dropped without any report. The frame decodes a 4 KiB window. Inside that window it also offers a read-only capability word, a read-only identity word and a block of identity registers that read as zero. Any access of the wrong size, or to an offset the frame does not define, produces a one-cycle error strobe.

Two elaboration parameters fix the range. `BASE_INDEX` places the first served number at `BASE_INDEX + 32`. `LINE_COUNT` sets the number of output lines and must lie between 1 and 128. The first served number plus the line count must not go past 1020. Elaboration stops with an error if either limit is broken. All register data is little-endian. Bit 0 of `bus_wdata` and `bus_rdata` is the least significant bit.

A small controller state machine records what the previous cycle's access was. Its states are `ST_IDLE` (nothing to present), `ST_RING` (a doorbell was accepted, so one line pulses), `ST_REPLY` (read data is presented) and `ST_FAULT` (the error strobe is raised). On every clock the machine moves from any state according to the access then on the bus:
- an in-range doorbell moves it to `ST_RING`;
- a legal read moves it to `ST_REPLY`;
- a faulty access moves it to `ST_FAULT`;
- an idle bus or an out-of-range doorbell moves it to `ST_IDLE`.

Top module: `msi_frame`

## Requirements
- R1: A 4-byte read at offset 0x008 returns, one cycle later, the first served number (`BASE_INDEX+32`) in bits [31:16] and `LINE_COUNT` in the low bits, with no error.
- R2: A 4-byte read at offset 0xFCC returns 0x0510_0000 one cycle later, with no error.
- R3: A 4-byte read at any offset from 0xFD0 through 0xFFC returns zero, with no error.
- R4: A write of size 2 or 4 at offset 0x040 takes bits [9:0] of the data as the interrupt number. When that number minus the first served number lies in 0..LINE_COUNT-1, the line with that index is high in exactly the next cycle. Bits above [9:0] have no effect.
- R5: A doorbell whose number lies below the first served number, or at or above the first served number plus `LINE_COUNT`, raises no line and no error.
- R6: Each accepted doorbell gives exactly one cycle of high level on its line, and at most one line is high in any cycle. Consecutive accepted writes to the same number keep that line high for as many cycles as there were writes.
- R7: A read whose `bus_size` (a count of bytes) is not 4 returns zero and raises `err_strobe` for one cycle.
- R8: A write whose `bus_size` is neither 2 nor 4 raises no line and raises `err_strobe` for one cycle.
- R9: A read at an offset outside 0x008, 0xFCC and 0xFD0..0xFFC, or a write at any offset other than 0x040, returns zero or is dropped, and raises `err_strobe` for one cycle.
- R10: When `bus_rd` and `bus_wr` are high in the same cycle, nothing is read and no line is raised. `err_strobe` rises in the next cycle.
- R11: Synchronous reset clears all lines, `err_strobe` and `bus_rdata`, and drops any doorbell that arrives in the same cycle. Outside the cycle that follows a legal read, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte offset within the 4 KiB window |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_size | input | 3 | Access width in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a legal read |
| irq_pulse | output | LINE_COUNT | Interrupt lines, one-cycle pulses |
| err_strobe | output | 1 | One-cycle flag for a faulty access |

## Verification
A line pulse from one doorbell shares a clock edge with the result of the next access. That result can be a read reply or an error strobe. The bench drives doorbells, legal reads and faulty accesses back to back on consecutive cycles, so a pulse from one access and the reply or strobe of the following one land on adjacent edges. A scoreboard predicts the full output set for every cycle from the requirements alone. It compares lines, read data and strobe together, so a reply that leaks into the wrong cycle, or a pulse that lingers, shows up as a miscompare.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

    // Byte offsets that the frame decodes
    localparam logic [11:0] OFS_CAPS     = 12'h008;
    localparam logic [11:0] OFS_DOORBELL = 12'h040;
    localparam logic [11:0] OFS_IDENT    = 12'hFCC;
    localparam logic [11:0] OFS_ZERO_LO  = 12'hFD0;
    localparam logic [11:0] OFS_ZERO_HI  = 12'hFFC;

    localparam int unsigned ID_W        = 10;
    localparam int unsigned SPI_FLOOR   = 32;
    localparam int unsigned ID_CEILING  = 1020;
    localparam int unsigned MAX_LINES   = 128;
    localparam logic [7:0]  PRODUCT_TAG = 8'h51;
    localparam int unsigned PRODUCT_LSB = 20;

    // Class of the access on the bus this cycle
    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_RING,
        ACC_READ,
        ACC_BAD
    } acc_kind_e;

    // Which word a legal read returns
    typedef enum logic [1:0] {
        RSEL_CAPS,
        RSEL_IDENT,
        RSEL_ZERO
    } rsel_e;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RING,
        ST_REPLY,
        ST_FAULT
    } ctrl_state_e;

endpackage

// File: rtl/msi_frame_decode.sv
module msi_frame_decode
    import msi_frame_pkg::*;
(
    input  logic [11:0] addr_i,
    input  logic        wr_i,
    input  logic        rd_i,
    input  logic [2:0]  size_i,
    output acc_kind_e   kind_o,
    output rsel_e       rsel_o
);

    logic size_word;
    logic size_half_or_word;
    logic in_zero_block;

    assign size_word         = (size_i == 3'd4);
    assign size_half_or_word = (size_i == 3'd2) || (size_i == 3'd4);
    assign in_zero_block     = (addr_i >= OFS_ZERO_LO) && (addr_i <= OFS_ZERO_HI);

    always_comb begin
        kind_o = ACC_NONE;
        rsel_o = RSEL_ZERO;
        if (rd_i && wr_i) begin
            kind_o = ACC_BAD;
        end else if (rd_i) begin
            if (!size_word) begin
                kind_o = ACC_BAD;
            end else if (addr_i == OFS_CAPS) begin
                kind_o = ACC_READ;
                rsel_o = RSEL_CAPS;
            end else if (addr_i == OFS_IDENT) begin
                kind_o = ACC_READ;
                rsel_o = RSEL_IDENT;
            end else if (in_zero_block) begin
                kind_o = ACC_READ;
                rsel_o = RSEL_ZERO;
            end else begin
                kind_o = ACC_BAD;
            end
        end else if (wr_i) begin
            if (!size_half_or_word) begin
                kind_o = ACC_BAD;
            end else if (addr_i == OFS_DOORBELL) begin
                kind_o = ACC_RING;
            end else begin
                kind_o = ACC_BAD;
            end
        end
    end

endmodule

// File: rtl/msi_frame_ring.sv
module msi_frame_ring
    import msi_frame_pkg::*;
#(
    parameter int unsigned FIRST_ID   = 32,
    parameter int unsigned LINE_COUNT = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [31:0]           wdata_i,
    input  logic                  load_i,
    input  logic                  fire_i,
    output logic                  in_range_o,
    output logic [LINE_COUNT-1:0] pulse_o
);

    localparam int unsigned IDX_W = (LINE_COUNT > 1) ? $clog2(LINE_COUNT) : 1;
    localparam logic [ID_W:0] LO_ID = (ID_W+1)'(FIRST_ID);
    localparam logic [ID_W:0] HI_ID = (ID_W+1)'(FIRST_ID + LINE_COUNT);

    logic [ID_W:0]  id_ext;
    logic [ID_W:0]  rel_id;
    logic [IDX_W-1:0] idx_q;
    logic [31:ID_W] wdata_unused;

    assign wdata_unused = wdata_i[31:ID_W];
    assign id_ext       = {1'b0, wdata_i[ID_W-1:0]};
    assign rel_id       = id_ext - LO_ID;
    assign in_range_o   = (id_ext >= LO_ID) && (id_ext < HI_ID);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (load_i) begin
            idx_q <= rel_id[IDX_W-1:0];
        end
    end

    for (genvar g = 0; g < LINE_COUNT; g++) begin : g_line
        assign pulse_o[g] = fire_i && (idx_q == IDX_W'(g));
    end

endmodule

// File: rtl/msi_frame_ctrl.sv
module msi_frame_ctrl
    import msi_frame_pkg::*;
#(
    parameter int unsigned FIRST_ID   = 32,
    parameter int unsigned LINE_COUNT = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  acc_kind_e   kind_i,
    input  rsel_e       rsel_i,
    input  logic        in_range_i,
    output logic        ring_load_o,
    output logic        ring_fire_o,
    output logic        err_o,
    output logic [31:0] rdata_o
);

    localparam logic [31:0] CAPS_WORD  = {16'(FIRST_ID), 16'(LINE_COUNT)};
    localparam logic [31:0] IDENT_WORD = 32'(PRODUCT_TAG) << PRODUCT_LSB;

    ctrl_state_e state_q, state_d;
    logic [31:0] reply_q, reply_d;

    // Next-state and reply selection
    always_comb begin
        state_d = ST_IDLE;
        reply_d = '0;
        unique case (kind_i)
            ACC_NONE: state_d = ST_IDLE;
            ACC_RING: state_d = in_range_i ? ST_RING : ST_IDLE;
            ACC_READ: begin
                state_d = ST_REPLY;
                unique case (rsel_i)
                    RSEL_CAPS:  reply_d = CAPS_WORD;
                    RSEL_IDENT: reply_d = IDENT_WORD;
                    default:    reply_d = '0;
                endcase
            end
            ACC_BAD:  state_d = ST_FAULT;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            reply_q <= '0;
        end else begin
            state_q <= state_d;
            reply_q <= reply_d;
        end
    end

    assign ring_load_o = (state_d == ST_RING) && !rst;

    // Outputs from the registered state
    always_comb begin
        ring_fire_o = 1'b0;
        err_o       = 1'b0;
        rdata_o     = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RING:  ring_fire_o = 1'b1;
            ST_REPLY: rdata_o     = reply_q;
            ST_FAULT: err_o       = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/msi_frame.sv
module msi_frame
    import msi_frame_pkg::*;
#(
    parameter int unsigned BASE_INDEX = 0,
    parameter int unsigned LINE_COUNT = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [11:0]           bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [2:0]            bus_size,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic [LINE_COUNT-1:0] irq_pulse,
    output logic                  err_strobe
);

    localparam int unsigned FIRST_ID = BASE_INDEX + SPI_FLOOR;

    if (LINE_COUNT < 1 || LINE_COUNT > MAX_LINES) begin : g_bad_count
        $error("msi_frame: LINE_COUNT out of range 1..128");
    end
    if (FIRST_ID + LINE_COUNT > ID_CEILING) begin : g_bad_base
        $error("msi_frame: served range passes interrupt number 1020");
    end

    acc_kind_e kind;
    rsel_e     rsel;
    logic      in_range;
    logic      ring_load;
    logic      ring_fire;

    msi_frame_decode u_decode (
        .addr_i (bus_addr),
        .wr_i   (bus_wr),
        .rd_i   (bus_rd),
        .size_i (bus_size),
        .kind_o (kind),
        .rsel_o (rsel)
    );

    msi_frame_ring #(
        .FIRST_ID   (FIRST_ID),
        .LINE_COUNT (LINE_COUNT)
    ) u_ring (
        .clk        (clk),
        .rst        (rst),
        .wdata_i    (bus_wdata),
        .load_i     (ring_load),
        .fire_i     (ring_fire),
        .in_range_o (in_range),
        .pulse_o    (irq_pulse)
    );

    msi_frame_ctrl #(
        .FIRST_ID   (FIRST_ID),
        .LINE_COUNT (LINE_COUNT)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .kind_i      (kind),
        .rsel_i      (rsel),
        .in_range_i  (in_range),
        .ring_load_o (ring_load),
        .ring_fire_o (ring_fire),
        .err_o       (err_strobe),
        .rdata_o     (bus_rdata)
    );

endmodule

// File: rtl/msi_frame_chk.sv
module msi_frame_chk #(
    parameter int unsigned LINE_COUNT = 64
) (
    input logic                  clk,
    input logic                  rst,
    input logic [11:0]           bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [2:0]            bus_size,
    input logic [31:0]           bus_rdata,
    input logic [LINE_COUNT-1:0] irq_pulse,
    input logic                  err_strobe
);

    AST_LINES_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_pulse)); // R6

    AST_PULSE_NEEDS_DOORBELL: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse != '0) |-> $past(bus_wr && !bus_rd && bus_addr == 12'h040
                                    && (bus_size == 3'd2 || bus_size == 3'd4))); // R4

    AST_FAULT_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        err_strobe |-> (irq_pulse == '0)); // R8

    AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        err_strobe |-> (bus_rdata == 32'h0)); // R7

    AST_DUAL_REQ_FAULT: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_wr) |=> err_strobe); // R10

    AST_IDENT_WORD: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_size == 3'd4 && bus_addr == 12'hFCC)
        |=> (bus_rdata == 32'h0510_0000)); // R2

endmodule

bind msi_frame msi_frame_chk #(.LINE_COUNT(LINE_COUNT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_size   (bus_size),
    .bus_rdata  (bus_rdata),
    .irq_pulse  (irq_pulse),
    .err_strobe (err_strobe)
);

// File: tb/msi_frame_test.sv
module msi_frame_test;

    localparam int BASE  = 40;
    localparam int N     = 48;
    localparam int FIRST = BASE + 32;   // 72, last served 119

    typedef struct packed {
        logic [31:0]  rdata;
        logic [N-1:0] pulse;
        logic         err;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [2:0]    bus_size = 3'd4;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_pulse;
    logic          err_strobe;

    int applied = 0;
    int bad     = 0;
    item_t exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    msi_frame #(.BASE_INDEX(BASE), .LINE_COUNT(N)) uut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_pulse  (irq_pulse),
        .err_strobe (err_strobe)
    );

    function automatic item_t predict(logic rd, logic wr, logic [2:0] sz,
                                      logic [11:0] a, logic [31:0] d);
        item_t it = '0;
        int id;
        if (rd && wr) begin
            it.err = 1'b1;
        end else if (rd) begin
            if (sz != 3'd4)                         it.err = 1'b1;
            else if (a == 12'h008)                  it.rdata = (32'(FIRST) << 16) | 32'(N);
            else if (a == 12'hFCC)                  it.rdata = 32'h0510_0000;
            else if (a >= 12'hFD0 && a <= 12'hFFC)  it.rdata = 32'h0;
            else                                    it.err = 1'b1;
        end else if (wr) begin
            if (sz != 3'd2 && sz != 3'd4)           it.err = 1'b1;
            else if (a != 12'h040)                  it.err = 1'b1;
            else begin
                id = int'(d[9:0]);
                if (id >= FIRST && id < FIRST + N)  it.pulse[id - FIRST] = 1'b1;
            end
        end
        return it;
    endfunction

    task automatic step(input logic rd, input logic wr, input logic [2:0] sz,
                        input logic [11:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_size = sz; bus_addr = a; bus_wdata = d;
        exp_q.push_back(predict(rd, wr, sz, a, d));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 3'd4, 12'h000, 32'h0, tag);
    endtask

    task automatic direct_check(input string tag);
        applied++;
        if (irq_pulse != '0 || err_strobe !== 1'b0 || bus_rdata != 32'h0) begin
            bad++;
            $display("FAIL %s: lines %h err %b rdata %h, expected all zero",
                     tag, irq_pulse, err_strobe, bus_rdata);
        end
    endtask

    // Monitor: one expected item per clock while the queue is filled
    initial begin
        item_t e;
        string t;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                applied++;
                if (bus_rdata !== e.rdata || irq_pulse !== e.pulse || err_strobe !== e.err) begin
                    bad++;
                    $display("FAIL %s: rdata %h lines %h err %b, expected rdata %h lines %h err %b",
                             t, bus_rdata, irq_pulse, err_strobe, e.rdata, e.pulse, e.err);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        direct_check("R11 reset state");
        rst = 1'b0;

        step(1'b1, 1'b0, 3'd4, 12'h008, 32'h0, "R1 caps read");
        step(1'b1, 1'b0, 3'd4, 12'hFCC, 32'h0, "R2 ident read");
        step(1'b1, 1'b0, 3'd4, 12'hFD0, 32'h0, "R3 zero block low");
        step(1'b1, 1'b0, 3'd4, 12'hFE4, 32'h0, "R3 zero block mid");
        step(1'b1, 1'b0, 3'd4, 12'hFFC, 32'h0, "R3 zero block high");
        idle("R11 rdata zero when idle");

        step(1'b0, 1'b1, 3'd4, 12'h040, 32'd72, "R4 first line");
        idle("R6 pulse ends");
        step(1'b0, 1'b1, 3'd4, 12'h040, 32'd119, "R4 last line");
        step(1'b0, 1'b1, 3'd4, 12'h040, 32'hABCD_FC00 | 32'd90, "R4 upper bits ignored");
        idle("R6 pulse ends");

        step(1'b0, 1'b1, 3'd4, 12'h040, 32'd71, "R5 below range");
        step(1'b0, 1'b1, 3'd4, 12'h040, 32'd120, "R5 above range");
        step(1'b0, 1'b1, 3'd4, 12'h040, 32'd0, "R5 zero id");
        step(1'b0, 1'b1, 3'd4, 12'h040, 32'd1023, "R5 max id");

        step(1'b0, 1'b1, 3'd4, 12'h040, 32'd80, "R6 repeat first");
        step(1'b0, 1'b1, 3'd4, 12'h040, 32'd80, "R6 repeat second");
        step(1'b0, 1'b1, 3'd4, 12'h040, 32'd81, "R6 neighbour");
        idle("R6 pulse ends");

        step(1'b1, 1'b0, 3'd2, 12'h008, 32'h0, "R7 half read");
        step(1'b1, 1'b0, 3'd1, 12'hFCC, 32'h0, "R7 byte read");
        step(1'b0, 1'b1, 3'd1, 12'h040, 32'd72, "R8 byte write");
        step(1'b0, 1'b1, 3'd3, 12'h040, 32'd73, "R8 three-byte write");
        step(1'b0, 1'b1, 3'd2, 12'h040, 32'd73, "R8 half write accepted");

        step(1'b1, 1'b0, 3'd4, 12'h00C, 32'h0, "R9 read undefined");
        step(1'b1, 1'b0, 3'd4, 12'hFCD, 32'h0, "R9 read near ident");
        step(1'b1, 1'b0, 3'd4, 12'h040, 32'h0, "R9 read doorbell");
        step(1'b0, 1'b1, 3'd4, 12'h008, 32'd72, "R9 write caps");
        step(1'b0, 1'b1, 3'd4, 12'h044, 32'd72, "R9 write undefined");

        step(1'b1, 1'b1, 3'd4, 12'h040, 32'd75, "R10 read and write");
        step(1'b0, 1'b1, 3'd4, 12'h040, 32'd76, "R4 doorbell then read");
        step(1'b1, 1'b0, 3'd4, 12'h008, 32'h0, "R1 read after doorbell");
        step(1'b0, 1'b1, 3'd4, 12'h040, 32'd77, "R4 doorbell after read");
        step(1'b0, 1'b1, 3'd4, 12'h0FC, 32'd78, "R9 fault after doorbell");
        idle("R11 quiet");
        idle("R11 quiet");

        // Doorbell arriving together with reset is dropped
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_size = 3'd4; bus_addr = 12'h040; bus_wdata = 32'd72;
        rst = 1'b1;
        @(negedge clk);
        direct_check("R11 doorbell during reset");
        bus_wr = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        direct_check("R11 after reset release");

        idle("R11 tail");
        idle("R11 tail");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule